// File: doc/BRIEF.md
# Triple-Copy Memory with Background Repair

This block stores every data word three times, in three identical dual-port RAM arrays. The user side has one port for writes and reads. A write puts the same word into all three copies. A read returns the bitwise two-of-three majority of the copies. Because of the vote, a bit that has flipped in one copy never reaches the user.

Upsets that pile up would in the end defeat the vote. To stop that, a repair engine runs all the time on the second port of each array, which the user side never touches. The engine steps through the address space. At each address it reads all three copies, votes, and writes the voted word back into any copy that disagrees. It never stalls user traffic and never waits for idle cycles.

The user side sees a disagreement flag, together with the engine's current address, its repair pulse and its wrap pulse.

Top module: `tmr_scrub_mem`

## Requirements
- R1: A write (`wr_en` high at a clock edge) stores `wdata` at `addr` in all three copies. A read (`rd_en` high at a clock edge) gives the stored word on `rdata` with `rd_valid` high in the cycle after that edge. `rd_valid` is low in the cycle after any edge where `rd_en` was low. Scrub activity never delays or blocks a user access.
- R2: `rdata` is the bitwise majority of the three copies. Any number of flipped bits in a single copy is masked. A bit flipped the same way in two copies wins the vote.
- R3: `mismatch` is high in a `rd_valid` cycle if any copy differs from the voted word at the address read. With no scrub disagreement and all copies equal, it stays low.
- R4: A read and a write to the same address at the same edge return the word stored before that write.
- R5: The scrub address starts at 0 after reset and is shown on `scrub_addr`. Each address takes exactly two cycles: a read cycle, then a check cycle. The address then goes up by one and wraps from 2^ADDR_W-1 to 0.
- R6: In the check cycle, if any copy differs from the vote, `mismatch` and `scrub_fix` are high. At the end of that cycle only the differing copies are rewritten with the voted word, so the disagreement is gone from then on.
- R7: If the user writes the address under scrub, at the edge that starts the check cycle or at the edge that ends it, the repair write is dropped and `scrub_fix` stays low. The user's data is what remains.
- R8: `scrub_wrap` is high only in the check cycle of address 2^ADDR_W-1.
- R9: While `rst_n` is low, `rd_valid`, `mismatch`, `scrub_fix` and `scrub_wrap` are low and `scrub_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | User write strobe |
| rd_en | input | 1 | User read strobe |
| addr | input | ADDR_W | User address |
| wdata | input | DATA_W | User write data |
| rdata | output | DATA_W | Voted read data |
| rd_valid | output | 1 | `rdata` is valid this cycle |
| mismatch | output | 1 | A user read or a scrub check saw disagreeing copies |
| scrub_addr | output | ADDR_W | Address currently under scrub |
| scrub_fix | output | 1 | A repair write is made at the end of this cycle |
| scrub_wrap | output | 1 | Check cycle of the last address |

## Verification
Some behaviour is checked by assertions on every cycle:
- the one-cycle read valid timing;
- the step-by-one, two-cycle progress of the scrub address;
- a repair pulse never appearing without a mismatch, or while a user write hits the scrubbed address;
- the wrap pulse being tied to the last address.

Other behaviour can only be shown by the bench scenarios, which flip bits inside single copies and then look at the user port:
- that the vote masks a bad copy;
- that a repair actually removes the disagreement, so a later flip of the same bit in another copy is still outvoted;
- that a user write racing a pending repair keeps its own data.

// File: rtl/tmrm_pkg.sv
// Shared definitions for the triple-copy memory with background repair.
package tmrm_pkg;
    // Number of redundant copies; the voter logic is written for three.
    localparam int unsigned NCOPY = 3;

    // Two-cycle scrub step: fetch the copies, then check and repair.
    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_CHECK = 1'b1
    } scrub_phase_t;
endpackage

// File: rtl/tmrm_dpram.sv
// Dual-port RAM, one copy of the triple store.
// Both ports read synchronously and return the old word on a same-edge write.
// Assumes the two ports never write the same address at the same edge; the
// scrub engine cancels its write in that case.
module tmrm_dpram #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage with read-before-write on both ports.
    always_ff @(posedge clk) begin
        if (a_re) a_rdata <= mem[a_addr];
        if (b_re) b_rdata <= mem[b_addr];
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
    end
endmodule

// File: rtl/tmrm_voter.sv
// Bitwise two-of-three voter with a per-copy disagreement vector.
// Purely combinational; assumes exactly three input words.
module tmrm_voter #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [tmrm_pkg::NCOPY-1:0][DATA_W-1:0] words,
    output logic [DATA_W-1:0]                      voted,
    output logic [tmrm_pkg::NCOPY-1:0]             disagree
);
    // Majority of each bit position.
    always_comb begin
        voted = (words[0] & words[1]) | (words[1] & words[2]) | (words[0] & words[2]);
    end

    // Flag every copy that differs from the vote.
    for (genvar i = 0; i < tmrm_pkg::NCOPY; i++) begin : g_cmp
        assign disagree[i] = (words[i] != voted);
    end
endmodule

// File: rtl/tmrm_scrub_ctrl.sv
// Background repair engine driving the spare port of every copy.
// It fetches one address, checks it on the next cycle, then advances.
// A user write to the scrubbed address during the step cancels the repair.
module tmrm_scrub_ctrl #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       usr_we,
    input  logic [ADDR_W-1:0]          usr_addr,
    input  logic [tmrm_pkg::NCOPY-1:0] disagree,
    input  logic [DATA_W-1:0]          voted,
    output logic                       b_re,
    output logic [ADDR_W-1:0]          b_addr,
    output logic [tmrm_pkg::NCOPY-1:0] b_we_mask,
    output logic [DATA_W-1:0]          b_wdata,
    output logic                       checking,
    output logic [ADDR_W-1:0]          scrub_addr,
    output logic                       scrub_fix,
    output logic                       scrub_wrap
);
    import tmrm_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    scrub_phase_t      phase_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              stale_q;
    logic              usr_hit;
    logic              cancel;

    // A user write to the scrub address makes the fetched words stale.
    always_comb begin
        usr_hit = usr_we && (usr_addr == ptr_q);
        cancel  = stale_q || usr_hit;
    end

    // Step sequencing: fetch, then check, then advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
            ptr_q   <= '0;
            stale_q <= 1'b0;
        end else if (phase_q == PH_FETCH) begin
            phase_q <= PH_CHECK;
            stale_q <= usr_hit;
        end else begin
            phase_q <= PH_FETCH;
            ptr_q   <= ptr_q + 1'b1;
            stale_q <= 1'b0;
        end
    end

    // Port-B controls and status outputs.
    always_comb begin
        checking   = (phase_q == PH_CHECK);
        b_re       = (phase_q == PH_FETCH);
        b_addr     = ptr_q;
        b_wdata    = voted;
        b_we_mask  = (checking && !cancel) ? disagree : '0;
        scrub_addr = ptr_q;
        scrub_fix  = |b_we_mask;
        scrub_wrap = checking && (ptr_q == LAST_ADDR);
    end
endmodule

// File: rtl/tmr_scrub_mem.sv
// Triple-copy memory: writes go to three dual-port arrays and reads are voted.
// The spare port of each array belongs to a repair engine that runs all the
// time. Read latency is one cycle. Array contents are not reset.
module tmr_scrub_mem #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              mismatch,
    output logic [ADDR_W-1:0] scrub_addr,
    output logic              scrub_fix,
    output logic              scrub_wrap
);
    import tmrm_pkg::*;

    logic [NCOPY-1:0][DATA_W-1:0] a_words;
    logic [NCOPY-1:0][DATA_W-1:0] b_words;
    logic [NCOPY-1:0]             a_dis;
    logic [NCOPY-1:0]             b_dis;
    logic [DATA_W-1:0]            b_voted;
    logic [NCOPY-1:0]             b_we_mask;
    logic                         b_re;
    logic [ADDR_W-1:0]            b_addr;
    logic [DATA_W-1:0]            b_wdata;
    logic                         checking;
    logic                         rd_valid_q;

    // Three identical copies; port A is the user's, port B the scrubber's.
    for (genvar i = 0; i < NCOPY; i++) begin : g_copy
        tmrm_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
            .clk     (clk),
            .a_we    (wr_en),
            .a_re    (rd_en),
            .a_addr  (addr),
            .a_wdata (wdata),
            .a_rdata (a_words[i]),
            .b_we    (b_we_mask[i]),
            .b_re    (b_re),
            .b_addr  (b_addr),
            .b_wdata (b_wdata),
            .b_rdata (b_words[i])
        );
    end

    tmrm_voter #(.DATA_W(DATA_W)) u_vote_usr (
        .words    (a_words),
        .voted    (rdata),
        .disagree (a_dis)
    );

    tmrm_voter #(.DATA_W(DATA_W)) u_vote_scrub (
        .words    (b_words),
        .voted    (b_voted),
        .disagree (b_dis)
    );

    tmrm_scrub_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_scrub (
        .clk        (clk),
        .rst_n      (rst_n),
        .usr_we     (wr_en),
        .usr_addr   (addr),
        .disagree   (b_dis),
        .voted      (b_voted),
        .b_re       (b_re),
        .b_addr     (b_addr),
        .b_we_mask  (b_we_mask),
        .b_wdata    (b_wdata),
        .checking   (checking),
        .scrub_addr (scrub_addr),
        .scrub_fix  (scrub_fix),
        .scrub_wrap (scrub_wrap)
    );

    // Read-valid tracks the one-cycle array read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= rd_en;
    end

    // Disagreement report from either the user vote or the scrub vote.
    always_comb begin
        rd_valid = rd_valid_q;
        mismatch = (rd_valid_q && (|a_dis)) || (checking && (|b_dis));
    end
endmodule

// File: rtl/tmr_scrub_mem_chk.sv
// Cycle-level properties of the triple-copy memory, bound to the top module.
module tmr_scrub_mem_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_valid,
    input logic              mismatch,
    input logic [ADDR_W-1:0] scrub_addr,
    input logic              scrub_fix,
    input logic              scrub_wrap
);
    // R1
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R1
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R5
    scrub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_addr != $past(scrub_addr)) |-> (scrub_addr == ADDR_W'($past(scrub_addr) + 1'b1)));

    // R5
    scrub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_addr != $past(scrub_addr)) |=> $stable(scrub_addr));

    // R6
    fix_needs_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_fix |-> mismatch);

    // R7
    fix_yields_to_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == scrub_addr)) |-> !scrub_fix);

    // R8
    wrap_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_wrap |-> (scrub_addr == {ADDR_W{1'b1}}));
endmodule

bind tmr_scrub_mem tmr_scrub_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .rd_valid   (rd_valid),
    .mismatch   (mismatch),
    .scrub_addr (scrub_addr),
    .scrub_fix  (scrub_fix),
    .scrub_wrap (scrub_wrap)
);

// File: tb/sim_tmr_scrub_mem.sv
// Scoreboard bench: reads push expectations, a negedge monitor compares them.
module sim_tmr_scrub_mem;
    localparam int unsigned DW = 16;
    localparam int unsigned AW = 4;
    localparam int unsigned DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rd_valid;
    logic          mismatch;
    logic [AW-1:0] scrub_addr;
    logic          scrub_fix;
    logic          scrub_wrap;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [DW-1:0] data;
        bit            chk_mm;
        bit            mm;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] gold [DEPTH];

    always #10 clk = ~clk;

    tmr_scrub_mem #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .mismatch(mismatch),
        .scrub_addr(scrub_addr), .scrub_fix(scrub_fix), .scrub_wrap(scrub_wrap)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Flip bits in one copy to model an upset.
    task automatic upset(input int cpy, input int a, input logic [DW-1:0] m);
        case (cpy)
            0: u0.g_copy[0].u_ram.mem[a] = u0.g_copy[0].u_ram.mem[a] ^ m;
            1: u0.g_copy[1].u_ram.mem[a] = u0.g_copy[1].u_ram.mem[a] ^ m;
            default: u0.g_copy[2].u_ram.mem[a] = u0.g_copy[2].u_ram.mem[a] ^ m;
        endcase
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        gold[a] = d;
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] d, input bit chk_mm,
                           input bit mm, input string tag);
        exp_t e;
        e.data = d; e.chk_mm = chk_mm; e.mm = mm; e.tag = tag;
        sb.push_back(e);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_scrub(input int a);
        for (int k = 0; k < 200; k++) begin
            if (scrub_addr == AW'(a)) return;
            @(negedge clk);
        end
        check("R5 scrub address reached", 32'(scrub_addr), 32'(a));
    endtask

    // Monitor: pop one expectation for every valid read.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                check("R1 unexpected rd_valid", 32'(1), 32'(0));
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " data"}, 32'(rdata), 32'(e.data));
                if (e.chk_mm) check({e.tag, " mismatch R3"}, 32'(mismatch), 32'(e.mm));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit found;
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 rd_valid", 32'(rd_valid), 0);
        check("R9 mismatch", 32'(mismatch), 0);
        check("R9 scrub_fix", 32'(scrub_fix), 0);
        check("R9 scrub_wrap", 32'(scrub_wrap), 0);
        check("R9 scrub_addr", 32'(scrub_addr), 0);
        rst_n = 1'b1;

        // R1: fill and read back every address, all copies agree
        for (int i = 0; i < DEPTH; i++) do_write(i, DW'(16'hA5C3 ^ (i * 16'h1357)));
        for (int i = 0; i < DEPTH; i++) do_read(i, gold[i], 1'b1, 1'b0, "R1 readback");
        // R1: back-to-back read after writes keeps one-cycle latency
        do_write(6, 16'h0F0F);
        do_read(6, 16'h0F0F, 1'b1, 1'b0, "R1 fresh write");

        // R4: same-edge read and write return the old word
        v = gold[3];
        sb.push_back('{data: v, chk_mm: 1'b1, mm: 1'b0, tag: "R4 read-before-write"});
        rd_en = 1'b1; wr_en = 1'b1; addr = 4'd3; wdata = 16'hBEEF;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; gold[3] = 16'hBEEF;
        do_read(3, 16'hBEEF, 1'b1, 1'b0, "R4 new word after");

        // R2/R3: one bad copy is outvoted and flagged
        upset(0, 7, 16'h00FF);
        do_read(7, gold[7], 1'b1, 1'b1, "R2 single copy masked");

        // R6: repair of copy 1 at address 5
        repeat (40) @(negedge clk);
        wait_scrub(4);
        upset(1, 5, 16'h0008);
        found = 1'b0;
        for (int k = 0; k < 80 && !found; k++) begin
            if (scrub_fix) begin
                found = 1'b1;
                check("R6 fix address", 32'(scrub_addr), 5);
                check("R6 mismatch with fix", 32'(mismatch), 1);
            end else begin
                @(negedge clk);
            end
        end
        check("R6 repair seen", 32'(found), 1);
        @(negedge clk);
        do_read(5, gold[5], 1'b1, 1'b0, "R6 copies agree after repair");
        upset(2, 5, 16'h0008);
        do_read(5, gold[5], 1'b1, 1'b1, "R6 same bit in other copy still masked");

        // R7: user write at the fetch edge cancels the repair
        wait_scrub(8);
        upset(0, 9, 16'h4000);
        wait_scrub(9);
        do_write(9, 16'h1234);
        check("R7 fix dropped (fetch-edge write)", 32'(scrub_fix), 0);
        check("R7 stale disagreement seen", 32'(mismatch), 1);

        // R7: user write at the check edge cancels the repair
        wait_scrub(10);
        upset(0, 11, 16'h0002);
        wait_scrub(11);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd11; wdata = 16'h5678;
        #1;
        check("R7 fix dropped (check-edge write)", 32'(scrub_fix), 0);
        check("R7 pending disagreement seen", 32'(mismatch), 1);
        @(negedge clk);
        wr_en = 1'b0; gold[11] = 16'h5678;
        do_read(9, 16'h1234, 1'b1, 1'b0, "R7 user data kept @9");
        do_read(11, 16'h5678, 1'b1, 1'b0, "R7 user data kept @11");

        // R5/R8: two cycles per address and wrap to zero
        wait_scrub(14);
        wait_scrub(15);
        check("R8 no wrap in fetch cycle", 32'(scrub_wrap), 0);
        @(negedge clk);
        check("R5 address held two cycles", 32'(scrub_addr), 15);
        check("R8 wrap in check cycle", 32'(scrub_wrap), 1);
        @(negedge clk);
        check("R5 wrap to zero", 32'(scrub_addr), 0);
        check("R8 wrap low after", 32'(scrub_wrap), 0);
        @(negedge clk);
        @(negedge clk);
        check("R5 step by one", 32'(scrub_addr), 1);

        // R2: the same bit flipped in two copies wins the vote
        upset(0, 2, 16'h8000);
        upset(1, 2, 16'h8000);
        do_read(2, gold[2] ^ 16'h8000, 1'b1, 1'b1, "R2 double-copy majority");

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", 32'(sb.size()), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule